// File: doc/BRIEF.md
# Phase and word alignment controller for a 7:1 serial receiver

This controller sits beside a 7:1 deserializing receiver. A second deserializer lane samples the forwarded clock line as if it were data and delivers a 7-bit clock word on every slow-clock cycle. The controller uses that word in two ways. First it places the sample point. It steps the sampling PLL through all of its output phases, one pulse per step. At each phase it judges whether the clock word is stable. It then finds the longest stretch of stable phases and moves the PLL back to the middle of that stretch. Second it fixes the framing. Once the sample point is placed, it pulses a slip output that shifts the deserializer and divider framing by one bit. It repeats the pulse until the clock word reads as the transmitted clock pattern.

Three status flags are produced, and all outputs are registered. The bit-lock flag means the sample point is centred. The word-lock flag means the framing is correct. The ready flag means both are done. If the PLL loses lock, the controller drops all three flags and starts over from the beginning.

Top module: `lvds_align_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `phase_step`, `phase_dir`, `word_slip`, `bit_lock`, `word_lock` and `ready` are all 0.
- R2: The first `phase_step` pulse appears 40 clock edges after `pll_lock` rises. This is 16 cycles of lock qualification, then 8 settle cycles, then 16 judged samples. While `pll_lock` is low, no step is issued.
- R3: Each `phase_step` pulse lasts one cycle. A full sweep judges 16 phases. It issues 15 pulses with `phase_dir`=1, which means one phase up.
- R4: A phase counts as good only when `clk_word` holds one value through 16 consecutive samples. That judgement begins 8 cycles after the phase was reached. A word that changes during the window makes the phase bad.
- R5: Phases are indexed 0 to 15 in sweep order, starting at the phase that was judged first. The chosen window is the longest run of consecutive good indices, with no wrap from 15 back to 0. When two runs are equally long, the earlier one wins.
- R6: If the run is accepted, the controller issues pulses with `phase_dir`=0, which means one phase down. It stops at index start + (length−1)/2, rounding down. Then it sets `bit_lock`.
- R7: A run is accepted only when its length is at least `win_size`. A `win_size` of 0 counts as 1. If no run is accepted, `bit_lock` stays 0 and a new sweep starts from the current phase.
- R8: Once `bit_lock` is set, the controller waits 8 cycles. It then compares `clk_word` with 7'b1100011 (bit 6 is the first serial bit). On a mismatch it issues a one-cycle `word_slip` pulse, waits 4 cycles and compares again.
- R9: If the word still mismatches after 7 slips, the controller clears `bit_lock`, sets the slip count back to 0 and restarts the phase sweep.
- R10: On a match, `word_lock` and `ready` are set and held. `ready` is high only while both `bit_lock` and `word_lock` are high.
- R11: When `pll_lock` is low at a clock edge, all three lock flags are 0 after that edge. The controller then waits for a fresh lock qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (word-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock | input | 1 | Sampling PLL is locked |
| clk_word | input | 7 | Deserialized forwarded-clock word |
| win_size | input | 5 | Minimum accepted count of good phases |
| phase_step | output | 1 | One-cycle request to move the PLL phase by one step |
| phase_dir | output | 1 | Step direction: 1 up, 0 down |
| word_slip | output | 1 | One-cycle request to slip the word framing by one bit |
| bit_lock | output | 1 | Sample point centred in the eye |
| word_lock | output | 1 | Clock word matches the expected pattern |
| ready | output | 1 | Both locks held |

## Verification
The hardest situation to reach from the ports is the set of cases where the phase search chooses between several runs. These include runs of equal length, runs that touch index 15, and runs just shorter than the window, where the outcome depends on the run length and nothing else. The bench closes the loop with a behavioural PLL and deserializer stub. The stub keeps an absolute phase and a slip offset. On phases marked good in a 16-bit mask it returns a rotated, stable clock word; on the other phases it returns a word that toggles every cycle. The bench sweeps run starts and lengths near-exhaustively. For each case it compares the final stub phase, the step counts and the slip count against values it computes from the mask. A stub that always returns a word that never matches drives the controller into the slip give-up path.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [3:0] {
    S_WAIT,
    S_SETTLE,
    S_JUDGE,
    S_EVAL,
    S_BACK,
    S_GAP,
    S_WSET,
    S_WCHK,
    S_WWAIT,
    S_DONE
  } align_state_t;

  localparam logic [6:0] CLK_PATTERN_7 = 7'b1100011;
endpackage

// File: rtl/align_stab_judge.sv
module align_stab_judge #(
  parameter int WBITS   = 7,
  parameter int SAMPLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WBITS-1:0] word,
  output logic             done,
  output logic             good
);
  localparam int CW = $clog2(SAMPLES + 1);

  logic [WBITS-1:0] ref_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;
  logic             ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ok_q   <= 1'b0;
      done   <= 1'b0;
      good   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        ref_q  <= word;
        cnt_q  <= CW'(1);
        busy_q <= 1'b1;
        ok_q   <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == CW'(SAMPLES - 1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          good   <= ok_q && (word == ref_q);
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (word != ref_q) ok_q <= 1'b0;
        end
      end
    end
  end

  // R4
  judge_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
endmodule

// File: rtl/align_run_track.sv
module align_run_track #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          valid,
  input  logic          good,
  output logic [PW-1:0] best_start,
  output logic [LW-1:0] best_len
);
  logic [PW-1:0] idx_q, cur_start_q;
  logic [LW-1:0] cur_len_q;
  logic [PW-1:0] nstart;
  logic [LW-1:0] nlen;

  always_comb begin
    nlen   = cur_len_q + 1'b1;
    nstart = (cur_len_q == '0) ? idx_q : cur_start_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q       <= '0;
      cur_start_q <= '0;
      cur_len_q   <= '0;
      best_start  <= '0;
      best_len    <= '0;
    end else if (valid) begin
      idx_q <= idx_q + 1'b1;
      if (good) begin
        cur_len_q   <= nlen;
        cur_start_q <= nstart;
        if (nlen > best_len) begin
          best_len   <= nlen;
          best_start <= nstart;
        end
      end else begin
        cur_len_q <= '0;
      end
    end
  end

  // R5
  run_break_chk: assert property (@(posedge clk) disable iff (rst || clear)
    (valid && !good) |=> (cur_len_q == '0));
endmodule

// File: rtl/lvds_align_ctrl.sv
module lvds_align_ctrl
  import align_pkg::*;
#(
  parameter int NPH       = 16,
  parameter int WBITS     = 7,
  parameter int LOCK_WAIT = 16,
  parameter int SETTLE    = 8,
  parameter int JUDGE_N   = 16,
  parameter int SLIP_WAIT = 4,
  parameter int MAX_SLIP  = 7,
  parameter logic [WBITS-1:0] CLK_PAT = CLK_PATTERN_7,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_lock,
  input  logic [WBITS-1:0] clk_word,
  input  logic [LW-1:0]    win_size,
  output logic             phase_step,
  output logic             phase_dir,
  output logic             word_slip,
  output logic             bit_lock,
  output logic             word_lock,
  output logic             ready
);
  localparam int TW = $clog2(LOCK_WAIT + SETTLE + SLIP_WAIT + 1);
  localparam int SW = $clog2(MAX_SLIP + 1);

  align_state_t  state;
  logic [TW-1:0] cnt_q;
  logic [PW-1:0] idx_q, back_q;
  logic [SW-1:0] slips_q;
  logic          trk_clr;

  logic          judge_start, judge_done, judge_good, judge_rst;
  logic [PW-1:0] best_start, target;
  logic [LW-1:0] best_len, win_eff, half_len;

  assign judge_start = (state == S_SETTLE) && (cnt_q == TW'(SETTLE - 1));
  assign judge_rst   = rst || !pll_lock;

  align_stab_judge #(.WBITS(WBITS), .SAMPLES(JUDGE_N)) judge_i (
    .clk(clk), .rst(judge_rst), .start(judge_start), .word(clk_word),
    .done(judge_done), .good(judge_good)
  );

  align_run_track #(.NPH(NPH)) track_i (
    .clk(clk), .rst(rst), .clear(trk_clr),
    .valid(judge_done && (state == S_JUDGE)), .good(judge_good),
    .best_start(best_start), .best_len(best_len)
  );

  always_comb begin
    win_eff  = (win_size == '0) ? LW'(1) : win_size;
    half_len = (best_len - 1'b1) >> 1;
    target   = best_start + PW'(half_len);
  end

  always_ff @(posedge clk) begin
    if (rst || !pll_lock) begin
      state      <= S_WAIT;
      cnt_q      <= '0;
      idx_q      <= '0;
      back_q     <= '0;
      slips_q    <= '0;
      trk_clr    <= 1'b1;
      phase_step <= 1'b0;
      phase_dir  <= 1'b0;
      word_slip  <= 1'b0;
      bit_lock   <= 1'b0;
      word_lock  <= 1'b0;
      ready      <= 1'b0;
    end else begin
      phase_step <= 1'b0;
      word_slip  <= 1'b0;
      trk_clr    <= 1'b0;
      case (state)
        S_WAIT: begin
          trk_clr <= 1'b1;
          if (cnt_q == TW'(LOCK_WAIT - 1)) begin
            state <= S_SETTLE;
            cnt_q <= '0;
            idx_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_SETTLE: begin
          if (cnt_q == TW'(SETTLE - 1)) begin
            state <= S_JUDGE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_JUDGE: begin
          if (judge_done) begin
            if (idx_q == PW'(NPH - 1)) state <= S_EVAL;
            else begin
              phase_step <= 1'b1;
              phase_dir  <= 1'b1;
              idx_q      <= idx_q + 1'b1;
              state      <= S_SETTLE;
            end
          end
        end
        S_EVAL: begin
          if (best_len >= win_eff) begin
            back_q <= PW'(NPH - 1) - target;
            state  <= S_BACK;
          end else begin
            trk_clr <= 1'b1;
            idx_q   <= '0;
            cnt_q   <= '0;
            state   <= S_SETTLE;
          end
        end
        S_BACK: begin
          if (back_q == '0) begin
            bit_lock <= 1'b1;
            slips_q  <= '0;
            cnt_q    <= '0;
            state    <= S_WSET;
          end else begin
            phase_step <= 1'b1;
            phase_dir  <= 1'b0;
            back_q     <= back_q - 1'b1;
            state      <= S_GAP;
          end
        end
        S_GAP: state <= S_BACK;
        S_WSET: begin
          if (cnt_q == TW'(SETTLE - 1)) state <= S_WCHK;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_WCHK: begin
          if (clk_word == CLK_PAT) begin
            word_lock <= 1'b1;
            ready     <= 1'b1;
            state     <= S_DONE;
          end else if (slips_q == SW'(MAX_SLIP)) begin
            bit_lock <= 1'b0;
            slips_q  <= '0;
            trk_clr  <= 1'b1;
            idx_q    <= '0;
            cnt_q    <= '0;
            state    <= S_SETTLE;
          end else begin
            word_slip <= 1'b1;
            slips_q   <= slips_q + 1'b1;
            cnt_q     <= '0;
            state     <= S_WWAIT;
          end
        end
        S_WWAIT: begin
          if (cnt_q == TW'(SLIP_WAIT - 1)) state <= S_WCHK;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_DONE: state <= S_DONE;
        default: state <= S_WAIT;
      endcase
    end
  end

  // R3
  step_pulse_chk: assert property (@(posedge clk) disable iff (rst) phase_step |=> !phase_step);
  // R8
  slip_pulse_chk: assert property (@(posedge clk) disable iff (rst) word_slip |=> !word_slip);
  // R10
  ready_both_chk: assert property (@(posedge clk) disable iff (rst) ready |-> (bit_lock && word_lock));
  // R11
  lock_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_lock |=> (!bit_lock && !word_lock && !ready));
  // R2
  lock_needed_chk: assert property (@(posedge clk) disable iff (rst) bit_lock |-> $past(pll_lock));
endmodule

// File: tb/lvds_align_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvds_align_ctrl_tb_top;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       pll_lock = 1'b0;
  logic [6:0] clk_word;
  logic [4:0] win_size = 5'd4;
  logic phase_step, phase_dir, word_slip, bit_lock, word_lock, ready;

  lvds_align_ctrl dut_i (
    .clk(clk), .rst(rst), .pll_lock(pll_lock), .clk_word(clk_word), .win_size(win_size),
    .phase_step(phase_step), .phase_dir(phase_dir), .word_slip(word_slip),
    .bit_lock(bit_lock), .word_lock(word_lock), .ready(ready)
  );

  // behavioural PLL + deserializer stub
  logic [15:0] cfg_mask = 16'h0;
  logic [2:0]  cfg_s0 = 3'd0;
  logic        cfg_bad = 1'b0;
  logic [3:0]  ph;
  logic [2:0]  sl;
  logic        tog;
  int nslip, nup, ndn;

  function automatic logic [6:0] rot7(input logic [6:0] p, input int k);
    logic [6:0] r;
    r = p;
    for (int i = 0; i < k; i++) r = {r[5:0], r[6]};
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph <= 4'd0; sl <= cfg_s0; tog <= 1'b0; nslip <= 0; nup <= 0; ndn <= 0;
    end else begin
      tog <= ~tog;
      if (phase_step) begin
        if (phase_dir) begin ph <= ph + 4'd1; nup <= nup + 1; end
        else begin ph <= ph - 4'd1; ndn <= ndn + 1; end
      end
      if (word_slip) begin
        sl <= (sl == 3'd6) ? 3'd0 : sl + 3'd1;
        nslip <= nslip + 1;
      end
    end
  end

  always_comb begin
    if (cfg_mask[ph]) clk_word = cfg_bad ? 7'h00 : rot7(PAT, int'(sl));
    else clk_word = tog ? 7'h55 : 7'h2A;
  end

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic longest(input logic [15:0] m, output int st, output int ln);
    int cs, cl;
    st = 0; ln = 0; cs = 0; cl = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > ln) begin ln = cl; st = cs; end
      end else cl = 0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; pll_lock = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [15:0] m, input int win, input int s0, input string tag);
    int st, ln, weff, tgt, n;
    bit seen;
    cfg_mask = m; cfg_s0 = 3'(s0); cfg_bad = 1'b0; win_size = 5'(win);
    do_reset();
    longest(m, st, ln);
    weff = (win == 0) ? 1 : win;
    if (ln >= weff) begin
      tgt = st + (ln - 1) / 2;
      n = 0;
      while (!ready && n < 2000) begin @(negedge clk); n++; end
      chk(ready && bit_lock && word_lock, {tag, " R10 ready"}, int'(ready), 1);
      chk(int'(ph) == tgt, {tag, " R4 R5 R6 parked phase"}, int'(ph), tgt);
      chk(nup == 15 && ndn == 15 - tgt, {tag, " R3 up steps"}, nup, 15);
      chk(nslip == (7 - s0) % 7, {tag, " R8 slips"}, nslip, (7 - s0) % 7);
    end else begin
      seen = 0;
      repeat (1000) begin @(negedge clk); if (bit_lock) seen = 1; end
      chk(!seen, {tag, " R7 no lock below window"}, int'(seen), 0);
      chk(nup >= 30, {tag, " R7 sweep restarted"}, nup, 30);
    end
  endtask

  initial begin
    int n;
    bit seen;
    // R1
    rst = 1'b1; pll_lock = 1'b1;
    repeat (3) @(negedge clk);
    chk({phase_step, phase_dir, word_slip, bit_lock, word_lock, ready} == 6'b0,
        "R1 outputs in reset", int'({phase_step, phase_dir, word_slip, bit_lock, word_lock, ready}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({phase_step, phase_dir, word_slip, bit_lock, word_lock, ready} == 6'b0,
        "R1 outputs after reset", int'({phase_step, phase_dir, word_slip, bit_lock, word_lock, ready}), 0);

    // single run from phase 0, every length
    for (int len = 1; len <= 16; len++)
      run_case(16'((32'h1 << len) - 1), 4, len % 7, "len-sweep");
    // run of 4 at every start
    for (int s = 0; s < 16; s++)
      run_case(16'(32'hF << s), 4, s % 7, "start-sweep");
    // R5 longest of two runs, tie broken by earlier
    run_case(16'b0001_1111_1000_1110, 4, 2, "R5 two runs");
    run_case(16'b0000_0000_1110_0111, 3, 1, "R5 tie");
    run_case(16'b0000_0000_0100_0000, 0, 0, "R7 zero window");
    run_case(16'hFFFF, 16, 6, "full window");
    run_case(16'b0011_1110_0000_0000, 5, 3, "R7 exact window");
    run_case(16'b0001_1110_0000_0000, 5, 3, "R7 short window");

    // R9 word never matches
    cfg_mask = 16'hFFFF; cfg_bad = 1'b1; cfg_s0 = 3'd0; win_size = 5'd4;
    do_reset();
    n = 0;
    while (!bit_lock && n < 2000) begin @(negedge clk); n++; end
    chk(bit_lock, "R9 bit lock reached", int'(bit_lock), 1);
    n = 0; seen = 0;
    while (bit_lock && n < 500) begin @(negedge clk); n++; if (word_lock) seen = 1; end
    chk(!bit_lock, "R9 bit lock dropped after give-up", int'(bit_lock), 0);
    chk(nslip == 7, "R9 slip count", nslip, 7);
    chk(!seen, "R9 no word lock", int'(seen), 0);
    cfg_bad = 1'b0;

    // R11 lock loss after ready, R2 restart timing
    run_case(16'b0000_0011_1111_0000, 4, 5, "pre-loss");
    pll_lock = 1'b0;
    @(negedge clk);
    chk(!bit_lock && !word_lock && !ready, "R11 flags cleared", int'({bit_lock, word_lock, ready}), 0);
    seen = 0;
    repeat (20) begin @(negedge clk); if (phase_step) seen = 1; end
    chk(!seen, "R2 no step while unlocked", int'(seen), 0);
    pll_lock = 1'b1;
    n = 0;
    while (!phase_step && n < 200) begin @(negedge clk); n++; end
    chk(n >= 40 && n <= 41, "R2 first step delay", n, 40);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule